// File: doc/BRIEF.md
# Selectable Twisted-Ring Multiphase Clock Divider

This block divides its input clock by any even factor from 2 to 16. It uses a ring of eight flip-flops in which the last active stage is inverted and fed back into the first stage. A 3-bit length select picks which stage closes the loop. With N active stages the ring runs at one 2N-th of the input rate with 50% duty. Each active stage gives the same divided clock, delayed by one input period from the stage before it. The block therefore also serves as a multiphase source with 360/(2N) degree spacing. With two active stages, for example, the four phases of a quarter-rate clock come from the two stages and their inverses.

A registered multiplexer, steered by its own 3-bit select, passes one chosen stage out on a single pin. A chain of toggle flip-flops, one deep by default, halves the ring rate again and gives a further 50% duty output. A synchronous reset and any change of the length select both clear the ring, so no state outside the legal ring sequence can survive. All pins are plain control or clock-like levels, with no handshake.

Top module: `twisted_ring_divider`

## Requirements
- R1: While `rst` is high at a rising edge, that edge drives `phase_o`, `pick_o` and `half_o` to 0.
- R2: The number of active stages is N = `len_sel` + 1. Bits of `phase_o` at index N and above read 0.
- R3: `phase_o[0]` has a period of exactly 2N input cycles and is high for N of them. This holds for every `len_sel` from 0 to 7, giving divisors 2, 4, ... 16.
- R4: After the ring has been cleared, `phase_o[0]` goes high on the first rising edge.
- R5: For 1 <= i < N, `phase_o[i]` equals `phase_o[i-1]` as it was one input cycle earlier.
- R6: On each edge, `phase_o[0]` takes the inverse of the previous value of `phase_o[N-1]`.
- R7: A rising edge that sees `len_sel` differ from the length now in use clears `phase_o` and `half_o` to 0. The ring then restarts under the new length as after reset.
- R8: `pick_o` equals `phase_o[phase_sel]` as it was one cycle earlier. A `phase_sel` of N or more therefore gives 0.
- R9: `half_o` toggles on each edge where `phase_o[0]` rises. With the default depth of 1 it has a period of 4N cycles at 50% duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| len_sel | input | 3 | Active stage count minus one |
| phase_sel | input | 3 | Stage index routed to `pick_o` |
| phase_o | output | 8 | Per-stage divided clock phases |
| pick_o | output | 1 | Registered copy of the selected phase |
| half_o | output | 1 | Ring clock further divided by toggle stages |

## Verification
On every cycle, the assertions check that each stage copies its neighbour with one cycle of delay, that the feedback inverts the last active stage, that unused stages stay low, and that the selected-phase register follows the bus. They also check that the toggle output only changes when the first stage rises, and that a length change clears everything. Only the bench scenarios show whole-waveform facts: the exact period and duty for each of the eight divisors, the first rise right after a clear, and the restart timing after a length change.

// File: rtl/twr_pkg.sv
package twr_pkg;

  // Stage idx is part of the ring when idx <= sel (sel = active count - 1).
  function automatic logic twr_stage_on(input int sel, input int idx);
    return idx <= sel;
  endfunction

endpackage

// File: rtl/twr_ring.sv
module twr_ring
  import twr_pkg::*;
#(
  parameter int STAGES = 8,
  parameter int SEL_W  = $clog2(STAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  len_sel,
  output logic [STAGES-1:0] ring_o,
  output logic              restart_o,
  output logic              lead_rise_o
);

  logic [STAGES-1:0] ring_q;
  logic [STAGES-1:0] ring_d;
  logic [STAGES-1:0] active;
  logic [SEL_W-1:0]  len_q;
  logic              fb_tap;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_mask
      assign active[gi] = twr_stage_on(int'(len_q), gi);
    end
  endgenerate

  assign fb_tap    = ring_q[len_q];
  assign ring_d    = {ring_q[STAGES-2:0], ~fb_tap} & active;
  assign restart_o = (len_sel != len_q);
  // first stage is about to rise: it is low and the tap it inverts is low
  assign lead_rise_o = ~restart_o & ~ring_q[0] & ~fb_tap;

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_q <= '0;
      len_q  <= len_sel;
    end else if (restart_o) begin
      ring_q <= '0;
      len_q  <= len_sel;
    end else begin
      ring_q <= ring_d;
    end
  end

  assign ring_o = ring_q;

endmodule

// File: rtl/twr_toggle.sv
module twr_toggle #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic q_o
);

  logic [DEPTH-1:0] tq;
  logic [DEPTH-1:0] carry;

  assign carry[0] = en;

  genvar gk;
  generate
    for (gk = 1; gk < DEPTH; gk++) begin : g_carry
      // next stage toggles when the previous one falls from 1 to 0
      assign carry[gk] = carry[gk-1] & tq[gk-1];
    end
    for (gk = 0; gk < DEPTH; gk++) begin : g_tff
      always_ff @(posedge clk) begin
        if (rst || clr) tq[gk] <= 1'b0;
        else            tq[gk] <= tq[gk] ^ carry[gk];
      end
    end
  endgenerate

  assign q_o = tq[DEPTH-1];

endmodule

// File: rtl/twr_phase_mux.sv
module twr_phase_mux #(
  parameter int STAGES = 8,
  parameter int SEL_W  = $clog2(STAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] phases,
  input  logic [SEL_W-1:0]  sel,
  output logic              pick_o
);

  always_ff @(posedge clk) begin
    if (rst) pick_o <= 1'b0;
    else     pick_o <= phases[sel];
  end

endmodule

// File: rtl/twisted_ring_divider.sv
module twisted_ring_divider #(
  parameter int STAGES     = 8,
  parameter int HALF_DEPTH = 1,
  localparam int SEL_W     = $clog2(STAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  len_sel,
  input  logic [SEL_W-1:0]  phase_sel,
  output logic [STAGES-1:0] phase_o,
  output logic              pick_o,
  output logic              half_o
);

  logic restart;
  logic lead_rise;

  twr_ring #(.STAGES(STAGES), .SEL_W(SEL_W)) u_ring (
    .clk         (clk),
    .rst         (rst),
    .len_sel     (len_sel),
    .ring_o      (phase_o),
    .restart_o   (restart),
    .lead_rise_o (lead_rise)
  );

  twr_phase_mux #(.STAGES(STAGES), .SEL_W(SEL_W)) u_mux (
    .clk    (clk),
    .rst    (rst),
    .phases (phase_o),
    .sel    (phase_sel),
    .pick_o (pick_o)
  );

  twr_toggle #(.DEPTH(HALF_DEPTH)) u_half (
    .clk (clk),
    .rst (rst),
    .clr (restart),
    .en  (lead_rise),
    .q_o (half_o)
  );

endmodule

// File: rtl/twr_checker.sv
module twr_checker
  import twr_pkg::*;
#(
  parameter int STAGES = 8,
  parameter int SEL_W  = $clog2(STAGES)
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  len_sel,
  input logic [SEL_W-1:0]  phase_sel,
  input logic [STAGES-1:0] phase_o,
  input logic              pick_o,
  input logic              half_o
);

  logic [SEL_W-1:0]  len_d1, len_d2, psel_d1;
  logic [STAGES-1:0] phase_d1;
  logic              half_d1;
  logic [1:0]        age;
  logic              live;
  logic              settled;
  logic [STAGES-1:0] upper;

  always_ff @(posedge clk) begin
    len_d1   <= len_sel;
    len_d2   <= len_d1;
    psel_d1  <= phase_sel;
    phase_d1 <= phase_o;
    half_d1  <= half_o;
    if (rst)           age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assign live    = (age != 2'd0);
  assign settled = live && (len_d1 == len_d2);

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_up
      assign upper[gi] = !twr_stage_on(int'(len_d1), gi);
    end
    for (gi = 1; gi < STAGES; gi++) begin : g_shift
      AST_STAGE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        settled && twr_stage_on(int'(len_d1), gi) |-> phase_o[gi] == phase_d1[gi-1]); // R5
    end
  endgenerate

  AST_UNUSED_LOW: assert property (@(posedge clk) disable iff (rst)
    settled |-> (phase_o & upper) == '0); // R2

  AST_FEEDBACK_INV: assert property (@(posedge clk) disable iff (rst)
    settled |-> phase_o[0] == !phase_d1[len_d1]); // R6

  AST_LEN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    live && (len_d1 != len_d2) |-> (phase_o == '0) && !half_o); // R7

  AST_PICK_LAG: assert property (@(posedge clk) disable iff (rst)
    live |-> pick_o == phase_d1[psel_d1]); // R8

  AST_HALF_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    settled && (half_o != half_d1) |-> phase_o[0] && !phase_d1[0]); // R9

endmodule

bind twisted_ring_divider twr_checker #(.STAGES(STAGES), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .len_sel   (len_sel),
  .phase_sel (phase_sel),
  .phase_o   (phase_o),
  .pick_o    (pick_o),
  .half_o    (half_o)
);

// File: tb/twisted_ring_divider_bench.sv
`timescale 1ns/1ps
module twisted_ring_divider_bench;

  localparam int STAGES = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] len_sel = 3'd0;
  logic [2:0] phase_sel = 3'd0;
  logic [7:0] phase_o;
  logic       pick_o;
  logic       half_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  twisted_ring_divider u_twisted_ring_divider (
    .clk(clk), .rst(rst), .len_sel(len_sel), .phase_sel(phase_sel),
    .phase_o(phase_o), .pick_o(pick_o), .half_o(half_o)
  );

  // expected stage value at sample t after a clear (t=0 is the clearing edge)
  function automatic logic stage_exp(input int idx, input int t, input int n);
    int tt;
    if (idx >= n) return 1'b0;
    tt = t - idx;
    if (tt < 1) return 1'b0;
    return ((tt - 1) % (2 * n)) < n;
  endfunction

  function automatic logic [7:0] bus_exp(input int t, input int n);
    logic [7:0] b;
    for (int i = 0; i < STAGES; i++) b[i] = stage_exp(i, t, n);
    return b;
  endfunction

  function automatic logic half_exp(input int t, input int n);
    if (t < 1) return 1'b0;
    return (((t - 1) / (2 * n)) % 2) == 0;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input int len);
    @(negedge clk);
    rst = 1'b1;
    len_sel = 3'(len);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(phase_o == 8'h00, "R1 phase", int'(phase_o), 0);
    check(pick_o == 1'b0,   "R1 pick",  int'(pick_o), 0);
    check(half_o == 1'b0,   "R1 half",  int'(half_o), 0);
  endtask

  // at a negedge right after a clearing edge; runs and checks cycles samples
  task automatic run_window(input int len, input int psel, input int cycles);
    int n = len + 1;
    int highs = 0;
    phase_sel = 3'(psel);
    for (int t = 1; t <= cycles; t++) begin
      @(posedge clk);
      @(negedge clk);
      check(phase_o == bus_exp(t, n), "R2 R3 R5 R6 bus", int'(phase_o), int'(bus_exp(t, n)));
      if (t == 1) check(phase_o[0] == 1'b1, "R4 first rise", int'(phase_o[0]), 1);
      if (t <= 2 * n && phase_o[0]) highs++;
      check(half_o == half_exp(t, n), "R9 half", int'(half_o), int'(half_exp(t, n)));
      check(pick_o == stage_exp(psel, t - 1, n), "R8 pick", int'(pick_o),
            int'(stage_exp(psel, t - 1, n)));
    end
    if (cycles >= 2 * n) check(highs == n, "R3 duty", highs, n);
  endtask

  task automatic scen_all_divisors();
    for (int len = 0; len < STAGES; len++) begin
      do_reset(len);
      run_window(len, len, 8 * (len + 1) + 3);
    end
  endtask

  task automatic scen_pick_range();
    do_reset(2);
    run_window(2, 6, 20);   // R8: index beyond N reads 0
    do_reset(5);
    run_window(5, 0, 30);
  endtask

  task automatic scen_len_change();
    do_reset(3);
    run_window(3, 1, 11);
    len_sel = 3'd1;
    @(posedge clk);
    @(negedge clk);
    check(phase_o == 8'h00, "R7 clear phase", int'(phase_o), 0);
    check(half_o == 1'b0,   "R7 clear half",  int'(half_o), 0);
    run_window(1, 1, 17);
    len_sel = 3'd7;
    @(posedge clk);
    @(negedge clk);
    check(phase_o == 8'h00, "R7 clear phase", int'(phase_o), 0);
    run_window(7, 4, 40);
  endtask

  initial begin
    scen_all_divisors();
    scen_pick_range();
    scen_len_change();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(10 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule